// File: doc/BRIEF.md
# LVDS Lane Bit Mapper and Serializer

The block takes a 28-bit parallel pixel word for each of two channels and spreads its bits over up to four serial data lanes per channel, seven bits per lane per pixel period. Every one of the seven slots on every lane has its own programmable source index. This lets one table describe any colour-depth packing, such as the 24-bit four-lane layout or the 18-bit three-lane layout. The source word holds 24 colour bits in bits 0..23, then horizontal sync (24), vertical sync (25), data enable (26) and one spare bit (27). A fixed clock-lane pattern is sent beside the data lanes.

The block runs on one fast clock at seven times the pixel rate. It generates its own pixel strobe, `pix_take`. Both pixel words are captured at the clock edge that ends a strobe cycle, and the following seven cycles shift them out. Software loads the slot table and a control word through a simple write port. It turns on serialization with a separate, later write, and that write is only honoured once the configuration has been left alone for a settle time.

Top module: `lvds_lane_mapper`

## Requirements
- R1: After reset, and whenever serialization is off, every data and clock output is 0.
- R2: `pix_take` is high for one cycle in every seven. Both pixel words are sampled at the rising edge that ends a `pix_take` cycle. The next seven cycles carry slot 6, 5, 4, 3, 2, 1 and then slot 0 on each lane.
- R3: Each slot outputs bit `src[idx]` of its channel's pixel word, where `idx` is that slot's index. An index of 28 or more drives 0. Address 2*L+0 holds lane L slots 0..3, and address 2*L+1 holds slots 4..6. Within each word, slot k sits at bits [8k+4:8k].
- R4: After reset the slot table holds the 24-bit layout. Slots 0..6 are: lane 0 = 8,5,4,3,2,1,0; lane 1 = 17,16,13,12,11,10,9; lane 2 = 26,25,24,21,20,19,18; lane 3 = 27,23,22,15,14,7,6.
- R5: An enabled clock lane sends 1,1,0,0,0,1,1 over the seven cycles of each pixel period, in time order.
- R6: The control word is at address 8. Bits [3:0] enable the channel 1 data lanes and bits [7:4] enable the channel 2 data lanes. Bit 8 enables the channel 1 clock lane and bit 9 enables the channel 2 clock lane. A disabled lane outputs 0.
- R7: When the single-channel bit (control bit 10) is 1, every channel 2 data and clock output is 0.
- R8: When the swap bit (control bit 11) is 1, the channel 1 pins carry the stream built from `pix_b`, and the channel 2 pins carry the stream built from `pix_a`. Lane enables stay tied to the pins.
- R9: Any write to the slot table or to the control word turns serialization off in the next cycle.
- R10: The serialization enable is bit 0 at address 9. A write of 1 takes effect only once SETTLE_CYC cycles have passed since reset or since the last table or control write. An earlier write of 1 is ignored.
- R11: Outputs stay 0 while the interface enable (control bit 12) is 0, even with serialization on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, seven times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW (4) | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| pix_a | input | SRC_W (28) | Pixel word for channel stream A |
| pix_b | input | SRC_W (28) | Pixel word for channel stream B |
| pix_take | output | 1 | Pixel strobe; the words are sampled at the edge that ends it |
| ch1_data | output | NLANE (4) | Channel 1 serial data lanes |
| ch2_data | output | NLANE (4) | Channel 2 serial data lanes |
| ch1_clk | output | 1 | Channel 1 clock lane |
| ch2_clk | output | 1 | Channel 2 clock lane |

## Verification
Two things can land on the same edge: a configuration write that disarms the serializer, and the reload of a new pixel into the shift registers. The bench provokes this by writing a new slot table directly after a frame and then sending a frame at once. It also writes the enable while the settle window is still open. In both cases the scoreboard expects all-zero lanes. Only after the settle time does re-arming bring the frame bits back, and those bits are judged against the new indices, including indices that select no bit.

// File: rtl/lvds_lane_mapper.sv
module lvds_lane_mapper #(
  parameter int NLANE      = 4,
  parameter int SRC_W      = 28,
  parameter int SETTLE_CYC = 250,
  parameter bit RESET_18BPP = 1'b0,
  localparam int AW = $clog2(2*NLANE+2)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [31:0]      cfg_wdata,
  input  logic [SRC_W-1:0] pix_a,
  input  logic [SRC_W-1:0] pix_b,
  output logic             pix_take,
  output logic [NLANE-1:0] ch1_data,
  output logic [NLANE-1:0] ch2_data,
  output logic             ch1_clk,
  output logic             ch2_clk
);
  localparam int SLOTS  = 7;
  localparam int IW     = $clog2(SRC_W);
  localparam int CTRL_A = 2*NLANE;
  localparam int SER_A  = CTRL_A + 1;
  localparam int CW     = $clog2(SETTLE_CYC+1);
  localparam int B_C1   = 2*NLANE;
  localparam int B_C2   = B_C1 + 1;
  localparam int B_SGL  = B_C1 + 2;
  localparam int B_SWP  = B_C1 + 3;
  localparam int B_ON   = B_C1 + 4;
  localparam int CB     = B_ON + 1;
  localparam logic [SLOTS-1:0] CLK_PAT = 7'b1100011;

  localparam int D24 [4][7] = '{'{8,5,4,3,2,1,0}, '{17,16,13,12,11,10,9},
                                '{26,25,24,21,20,19,18}, '{27,23,22,15,14,7,6}};
  localparam int D18 [4][7] = '{'{10,7,6,5,4,3,2}, '{19,18,15,14,13,12,11},
                                '{26,25,24,23,22,21,20}, '{-1,-1,-1,-1,-1,-1,-1}};

  function automatic logic [IW-1:0] dflt(int l, int s);
    int v;
    if (l > 3) return '1;
    v = RESET_18BPP ? D18[l][s] : D24[l][s];
    return (v < 0) ? '1 : IW'(v);
  endfunction

  logic [CB-1:0]    ctrl_q;
  logic             ser_en_q;
  logic [CW-1:0]    settle_q;
  logic [2:0]       ph_q;
  logic [SLOTS-1:0] shc_q;
  logic [NLANE-1:0] s1, s2, p1, p2;
  logic             unused_bits;

  wire load   = (ph_q == 3'd6);
  wire map_wr = cfg_we && (cfg_addr <  AW'(CTRL_A));
  wire ctl_wr = cfg_we && (cfg_addr == AW'(CTRL_A));
  wire ser_wr = cfg_we && (cfg_addr == AW'(SER_A));
  assign pix_take    = load;
  assign unused_bits = ^cfg_wdata;

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    logic [IW-1:0]    mq [SLOTS];
    logic [SLOTS-1:0] wa, wb, sa, sb;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        for (int s = 0; s < SLOTS; s++) mq[s] <= dflt(l, s);
      end else if (map_wr && cfg_addr[AW-1:1] == (AW-1)'(l)) begin
        if (!cfg_addr[0]) for (int s = 0; s < 4; s++) mq[s]   <= cfg_wdata[8*s +: IW];
        else              for (int s = 0; s < 3; s++) mq[4+s] <= cfg_wdata[8*s +: IW];
      end

    always_comb
      for (int s = 0; s < SLOTS; s++) begin
        wa[s] = (int'(mq[s]) < SRC_W) ? pix_a[mq[s]] : 1'b0;
        wb[s] = (int'(mq[s]) < SRC_W) ? pix_b[mq[s]] : 1'b0;
      end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)    begin sa <= '0; sb <= '0; end
      else if (load) begin sa <= wa; sb <= wb; end
      else           begin sa <= {sa[SLOTS-2:0], 1'b0}; sb <= {sb[SLOTS-2:0], 1'b0}; end

    assign s1[l] = sa[SLOTS-1];
    assign s2[l] = sb[SLOTS-1];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ph_q  <= '0;
      shc_q <= '0;
    end else begin
      ph_q  <= load ? 3'd0 : ph_q + 3'd1;
      shc_q <= load ? CLK_PAT : {shc_q[SLOTS-2:0], 1'b0};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl_q   <= '0;
      ser_en_q <= 1'b0;
      settle_q <= CW'(SETTLE_CYC);
    end else begin
      if (settle_q != '0) settle_q <= settle_q - 1'b1;
      if (ctl_wr) ctrl_q <= cfg_wdata[CB-1:0];
      if (map_wr || ctl_wr) begin
        ser_en_q <= 1'b0;
        settle_q <= CW'(SETTLE_CYC);
      end else if (ser_wr && (settle_q == '0 || !cfg_wdata[0])) begin
        ser_en_q <= cfg_wdata[0];
      end
    end

  wire act  = ser_en_q & ctrl_q[B_ON];
  wire act2 = act & ~ctrl_q[B_SGL];
  assign p1 = ctrl_q[B_SWP] ? s2 : s1;
  assign p2 = ctrl_q[B_SWP] ? s1 : s2;
  assign ch1_data = {NLANE{act}}  & ctrl_q[NLANE-1:0]       & p1;
  assign ch2_data = {NLANE{act2}} & ctrl_q[2*NLANE-1:NLANE] & p2;
  assign ch1_clk  = act  & ctrl_q[B_C1] & shc_q[SLOTS-1];
  assign ch2_clk  = act2 & ctrl_q[B_C2] & shc_q[SLOTS-1];
endmodule

// File: rtl/lvds_lane_mapper_chk.sv
module lvds_lane_mapper_chk #(
  parameter int NLANE = 4,
  parameter int AW    = 4
)(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [AW-1:0]    cfg_addr,
  input logic             pix_take,
  input logic [NLANE-1:0] ch1_data,
  input logic [NLANE-1:0] ch2_data,
  input logic             ch1_clk,
  input logic             ch2_clk,
  input logic             ser_en,
  input logic             settle_done,
  input logic             single
);
  logic [2:0] gap;
  logic       seen;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (pix_take) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (gap != 3'd7) begin
      gap  <= gap + 3'd1;
    end

  assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_en |-> (ch1_data == '0 && ch2_data == '0 && !ch1_clk && !ch2_clk));

  assert_strobe_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_take && seen |-> gap == 3'd6);

  assert_clock_wraps_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pix_take && ch1_clk && !cfg_we |=> ch1_clk);

  assert_single_channel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    single |-> (ch2_data == '0 && !ch2_clk));

  assert_cfg_disarms_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr <= AW'(2*NLANE) |=> !ser_en);

  assert_enable_after_settle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_en) |-> $past(settle_done));
endmodule

bind lvds_lane_mapper lvds_lane_mapper_chk #(.NLANE(NLANE), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .pix_take(pix_take), .ch1_data(ch1_data), .ch2_data(ch2_data),
  .ch1_clk(ch1_clk), .ch2_clk(ch2_clk), .ser_en(ser_en_q),
  .settle_done(settle_q == '0), .single(ctrl_q[2*NLANE+2]));

// File: tb/lvds_lane_mapper_test.sv
`timescale 1ns/1ps
module lvds_lane_mapper_test;
  localparam int CTRL = 8, SER = 9, WAIT_SET = 260;
  localparam logic [6:0] PAT = 7'b1100011;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0, cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [27:0] pix_a = '0, pix_b = '0;
  logic        pix_take, ch1_clk, ch2_clk;
  logic [3:0]  ch1_data, ch2_data;

  lvds_lane_mapper uut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pix_a(pix_a), .pix_b(pix_b), .pix_take(pix_take),
    .ch1_data(ch1_data), .ch2_data(ch2_data), .ch1_clk(ch1_clk), .ch2_clk(ch2_clk));

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int m [4][7] = '{'{8,5,4,3,2,1,0}, '{17,16,13,12,11,10,9},
                   '{26,25,24,21,20,19,18}, '{27,23,22,15,14,7,6}};
  logic [3:0] en1 = '0, en2 = '0;
  logic k1 = 0, k2 = 0, sgl = 0, swp = 0, ion = 0, ser = 0;
  logic [9:0] q[$];
  string tq[$];

  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic pick(logic [27:0] w, int i);
    return (i < 28) ? w[i] : 1'b0;
  endfunction

  always @(negedge clk)
    if (q.size() > 0) begin
      logic [9:0] e;
      string t;
      e = q.pop_front();
      t = tq.pop_front();
      check(t, {22'd0, ch2_clk, ch1_clk, ch2_data, ch1_data}, {22'd0, e});
    end

  task automatic send(logic [27:0] a, logic [27:0] b, string tag);
    do @(negedge clk); while (!pix_take);
    pix_a = a; pix_b = b;
    @(posedge clk);
    for (int k = 0; k < 7; k++) begin
      int sl;
      logic act;
      logic [3:0] d1, d2;
      logic c1, c2;
      sl  = 6 - k;
      act = ser & ion;
      for (int l = 0; l < 4; l++) begin
        logic sa, sb;
        sa = pick(a, m[l][sl]);
        sb = pick(b, m[l][sl]);
        d1[l] = act & en1[l] & (swp ? sb : sa);
        d2[l] = act & ~sgl & en2[l] & (swp ? sa : sb);
      end
      c1 = act & k1 & PAT[sl];
      c2 = act & ~sgl & k2 & PAT[sl];
      q.push_back({c2, c1, d2, d1});
      tq.push_back(tag);
    end
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic wr(int addr, logic [31:0] d);
    drain();
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (addr <= CTRL) ser = 1'b0;
  endtask

  task automatic wctrl(logic [3:0] e1, logic [3:0] e2, logic c1, logic c2,
                       logic sg, logic sw, logic on);
    en1 = e1; en2 = e2; k1 = c1; k2 = c2; sgl = sg; swp = sw; ion = on;
    wr(CTRL, {19'd0, on, sw, sg, c2, c1, e2, e1});
  endtask

  task automatic wmap(int lane, int half, int i0, int i1, int i2, int i3);
    if (half == 0) begin m[lane][0] = i0; m[lane][1] = i1; m[lane][2] = i2; m[lane][3] = i3; end
    else           begin m[lane][4] = i0; m[lane][5] = i1; m[lane][6] = i2; end
    wr(2*lane + half, {3'd0, 5'(i3), 3'd0, 5'(i2), 3'd0, 5'(i1), 3'd0, 5'(i0)});
  endtask

  task automatic arm(bit ok);
    wr(SER, 32'd1);
    if (ok) ser = 1'b1;
  endtask

  task automatic settle();
    repeat (WAIT_SET) @(negedge clk);
  endtask

  task automatic period_check();
    int n;
    do @(negedge clk); while (!pix_take);
    n = 0;
    do begin @(negedge clk); n++; end while (!pix_take);
    check("R2 strobe period", n, 7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {22'd0, ch2_clk, ch1_clk, ch2_data, ch1_data}, 0);
    rst_n = 1'b1;
    period_check();
    period_check();
    send(28'hFFFFFFF, 28'hFFFFFFF, "R1 off after reset");
    // dual channel, all lanes and clocks on
    wctrl(4'hF, 4'hF, 1, 1, 0, 0, 1);
    settle();
    arm(1);
    send(28'h0000100, 28'h0, "R4 lane0 slot0 source 8");
    send(28'h0ABCDEF, 28'h5123456, "R4 default map");
    send(28'h8000000, 28'h4000001, "R4 default map spare and bit0");
    send(28'h0, 28'h0, "R5 clock pattern");
    for (int i = 0; i < 4; i++) send(28'(1) << (7*i+3), 28'(1) << (27-i), "R2 slot order");
    // custom map for lane 0, including indices that select nothing
    wmap(0, 0, 27, 0, 31, 13);
    send(28'hFFFFFFF, 28'h0F0F0F0, "R9 disarmed by table write");
    wmap(0, 1, 29, 26, 1, 0);
    arm(0);
    send(28'hFFFFFFF, 28'hFFFFFFF, "R10 early enable ignored");
    settle();
    arm(1);
    send(28'hFFFFFFF, 28'h0, "R3 custom indices all ones");
    send(28'h4002001, 28'h8000002, "R3 custom indices sparse");
    send(28'h0000000, 28'hFFFFFFF, "R3 out of range on b");
    // lane enables
    wctrl(4'b0101, 4'b1010, 1, 0, 0, 0, 1);
    send(28'hFFFFFFF, 28'hFFFFFFF, "R9 disarmed by control write");
    settle();
    arm(1);
    send(28'hFFFFFFF, 28'hFFFFFFF, "R6 lane enables");
    send(28'h3C3C3C3, 28'hA5A5A5A, "R6 lane enables pattern");
    // single channel
    wctrl(4'hF, 4'hF, 1, 1, 1, 0, 1);
    settle();
    arm(1);
    send(28'hFFFFFFF, 28'hFFFFFFF, "R7 single channel");
    // channel swap
    wctrl(4'hF, 4'h3, 1, 1, 0, 1, 1);
    settle();
    arm(1);
    send(28'hFFFFFFF, 28'h0, "R8 swap a to ch2");
    send(28'h1234567, 28'hFEDCBA9, "R8 swap mixed");
    // interface enable off
    wctrl(4'hF, 4'hF, 1, 1, 0, 0, 0);
    settle();
    arm(1);
    send(28'hFFFFFFF, 28'hFFFFFFF, "R11 interface off");
    drain();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule